// File: doc/BRIEF.md
# Half-Rate Speculative Decision Feedback Equalizer

This block equalizes a serial bit stream that arrives as pairs of signed sample words from an upstream converter. Each clock carries one even sample and one odd sample. The even sample is the earlier bit of the pair in serial order. Two interleaved slicing paths turn the pair into two decided bits per clock. Each path removes the inter-symbol interference left by the five most recent decisions: it subtracts each tap weight multiplied by the polarity of the matching earlier bit, then slices the remainder to one bit.

The nearest post-cursor tap is not fed back through a closed loop. Each path computes its slicer result for both possible values of the immediately preceding bit, and a two-input mux picks the right one. The even path takes its select from the odd decision of the previous word. The odd path takes its select from the even decision of the same word, so the two muxes form a short chain. The four later taps come from a registered history of decisions kept in serial order. The tap weights travel with each sample pair and are applied to that pair.

A sample pair presented with `in_valid` high is registered, then decided in the next cycle. Both decisions and `dec_valid` are visible two clock edges after the pair is accepted. Adapting the tap weights is left to logic outside the block.

Top module: `dfe_half_rate`

## Requirements
- R1: After a synchronous reset, `dec_valid`, `dec_even` and `dec_odd` are all 0.
- R2: `dec_valid` equals `in_valid` delayed by two clock edges. A pair accepted at edge k shows its decisions after edge k+2.
- R3: The even decision uses y = x_even − Σ w_k·p(b_k), summed over k = 1..5. Here b_k is the bit k positions earlier in serial order. Tap 1 uses the previous word's odd decision, which selects between two precomputed candidates.
- R4: For tap 1, the odd decision uses the even decision of the same word. Taps 2..5 of the odd path use the previous word's odd bit, then its even bit, and so on further back.
- R5: Decided bits map to polarity p = +1 for bit 1 and p = −1 for bit 0. Bits from both paths are interleaved in serial order in the history, with the even bit before the odd bit within each word.
- R6: The slicer outputs 1 when the equalized value is zero or positive, and 0 when it is negative.
- R7: After reset, all five history bits are 0, so the first pair is equalized as if every earlier bit were −1.
- R8: Samples and taps are 8-bit two's complement. The sum never wraps, so any mix of extreme values gives the mathematically correct sign.
- R9: A cycle with `in_valid` low changes neither the decision outputs nor the history. The next valid pair continues from the last valid decisions.
- R10: `tap_w[8k+7:8k]` holds tap k+1. The weights are captured together with the samples, so each pair is equalized with the weights presented beside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair on the inputs is valid |
| samp_even | input | 8 | Earlier sample of the pair, signed |
| samp_odd | input | 8 | Later sample of the pair, signed |
| tap_w | input | 40 | Five signed tap weights, tap 1 in the low byte |
| dec_even | output | 1 | Decided even bit |
| dec_odd | output | 1 | Decided odd bit |
| dec_valid | output | 1 | Decisions belong to a valid pair |

## Verification
The assertions check the following on every cycle:
- the two-edge alignment between `in_valid` and `dec_valid`;
- that the outputs freeze after an idle input cycle;
- that the history shifts by exactly two positions per valid pair;
- that each speculative mux returns the common value whenever its two candidates agree.

The arithmetic needs the bench's scenarios. These cover the correct select bit for each path, the serial interleaving of the history, the tie at zero, the initial −1 history after reset, and sums at the extremes of the sample and tap ranges. They can only be shown by comparing whole decision sequences against a model of the equalization equation.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

    // Width that holds sample minus the sum of n_taps weighted polarities, with no wrap.
    function automatic int sum_width(input int w_samp, input int w_tap, input int n_taps);
        int wmax;
        wmax = (w_samp > w_tap) ? w_samp : w_tap;
        return wmax + $clog2(n_taps + 1) + 1;
    endfunction

endpackage

// File: rtl/dfe_isi_sum.sv
// Sum of N_IN weights, each signed by the polarity of one history bit.
module dfe_isi_sum #(
    parameter int W_TAP = 8,
    parameter int N_IN  = 4,
    parameter int SUM_W = 12
) (
    input  logic [N_IN*W_TAP-1:0]   w,
    input  logic [N_IN-1:0]         pol,
    output logic signed [SUM_W-1:0] isi
);

    logic signed [SUM_W-1:0] term [N_IN];

    generate
        for (genvar k = 0; k < N_IN; k++) begin : g_term
            logic signed [W_TAP-1:0] wk;
            logic signed [SUM_W-1:0] wx;
            assign wk      = w[k*W_TAP +: W_TAP];
            assign wx      = {{(SUM_W-W_TAP){wk[W_TAP-1]}}, wk};
            assign term[k] = pol[k] ? wx : -wx;
        end
    endgenerate

    always_comb begin
        isi = '0;
        for (int k = 0; k < N_IN; k++) begin
            isi = isi + term[k];
        end
    end

endmodule

// File: rtl/dfe_spec_slice.sv
// One path: both candidate slicer results for the unknown preceding bit.
module dfe_spec_slice #(
    parameter int W_SAMP = 8,
    parameter int W_TAP  = 8,
    parameter int SUM_W  = 12
) (
    input  logic [W_SAMP-1:0]       x,
    input  logic signed [SUM_W-1:0] isi,
    input  logic [W_TAP-1:0]        w1,
    output logic                    bit_if0,
    output logic                    bit_if1
);

    logic signed [SUM_W-1:0] x_ext;
    logic signed [SUM_W-1:0] w1_ext;
    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] y_if0;
    logic signed [SUM_W-1:0] y_if1;

    always_comb begin
        x_ext   = {{(SUM_W-W_SAMP){x[W_SAMP-1]}}, x};
        w1_ext  = {{(SUM_W-W_TAP){w1[W_TAP-1]}}, w1};
        base    = x_ext - isi;
        // preceding bit 0 is polarity -1, so its tap term is added back
        y_if0   = base + w1_ext;
        y_if1   = base - w1_ext;
        bit_if0 = ~y_if0[SUM_W-1];
        bit_if1 = ~y_if1[SUM_W-1];
    end

endmodule

// File: rtl/dfe_half_rate.sv
module dfe_half_rate
    import dfe_pkg::*;
#(
    parameter int W_SAMP = 8,
    parameter int W_TAP  = 8,
    parameter int N_TAPS = 5   // at least 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [W_SAMP-1:0]        samp_even,
    input  logic [W_SAMP-1:0]        samp_odd,
    input  logic [N_TAPS*W_TAP-1:0]  tap_w,
    output logic                     dec_even,
    output logic                     dec_odd,
    output logic                     dec_valid
);

    localparam int SUM_W = sum_width(W_SAMP, W_TAP, N_TAPS);
    localparam int TW    = N_TAPS * W_TAP;
    localparam int N_HI  = N_TAPS - 1;

    typedef struct packed {
        logic              v1;
        logic [TW-1:0]     taps;
        logic [W_SAMP-1:0] xe;
        logic [W_SAMP-1:0] xo;
        logic              vout;
        logic [N_TAPS-1:0] hist;   // bit 0 is the most recent decision
    } st_t;

    st_t st_d, st_q;

    logic signed [SUM_W-1:0] isi_e;
    logic signed [SUM_W-1:0] isi_o;
    logic e_if0, e_if1, o_if0, o_if1;
    logic dec_e_c, dec_o_c;

    // Taps 2..N: the even path looks one bit further back than the odd path.
    dfe_isi_sum #(.W_TAP(W_TAP), .N_IN(N_HI), .SUM_W(SUM_W)) isi_even_i (
        .w   (st_q.taps[TW-1:W_TAP]),
        .pol (st_q.hist[N_TAPS-1:1]),
        .isi (isi_e)
    );

    dfe_isi_sum #(.W_TAP(W_TAP), .N_IN(N_HI), .SUM_W(SUM_W)) isi_odd_i (
        .w   (st_q.taps[TW-1:W_TAP]),
        .pol (st_q.hist[N_TAPS-2:0]),
        .isi (isi_o)
    );

    dfe_spec_slice #(.W_SAMP(W_SAMP), .W_TAP(W_TAP), .SUM_W(SUM_W)) slice_even_i (
        .x       (st_q.xe),
        .isi     (isi_e),
        .w1      (st_q.taps[W_TAP-1:0]),
        .bit_if0 (e_if0),
        .bit_if1 (e_if1)
    );

    dfe_spec_slice #(.W_SAMP(W_SAMP), .W_TAP(W_TAP), .SUM_W(SUM_W)) slice_odd_i (
        .x       (st_q.xo),
        .isi     (isi_o),
        .w1      (st_q.taps[W_TAP-1:0]),
        .bit_if0 (o_if0),
        .bit_if1 (o_if1)
    );

    // Speculation resolve chain: previous odd bit -> even, then even -> odd.
    always_comb begin
        dec_e_c = st_q.hist[0] ? e_if1 : e_if0;
        dec_o_c = dec_e_c      ? o_if1 : o_if0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.v1   = in_valid;
        if (in_valid) begin
            st_d.taps = tap_w;
            st_d.xe   = samp_even;
            st_d.xo   = samp_odd;
        end
        st_d.vout = st_q.v1;
        if (st_q.v1) begin
            st_d.hist = {st_q.hist[N_TAPS-3:0], dec_e_c, dec_o_c};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_even  = st_q.hist[1];
    assign dec_odd   = st_q.hist[0];
    assign dec_valid = st_q.vout;

endmodule

// File: rtl/dfe_half_rate_chk.sv
module dfe_half_rate_chk #(
    parameter int N_TAPS = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              dec_valid,
    input logic              dec_even,
    input logic              dec_odd,
    input logic              stage_v,
    input logic [N_TAPS-1:0] hist,
    input logic              e_if0,
    input logic              e_if1,
    input logic              o_if0,
    input logic              o_if1
);

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd0) |-> (!dec_valid && !dec_even && !dec_odd));

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (dec_valid == $past(in_valid, 2)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && !$past(in_valid, 2)) |-> ($stable(dec_even) && $stable(dec_odd)));

    // R3
    even_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_v && (e_if0 == e_if1)) |=> (dec_even == $past(e_if0)));

    // R4
    odd_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (stage_v && (o_if0 == o_if1)) |=> (dec_odd == $past(o_if0)));

    // R5
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        stage_v |=> (hist[N_TAPS-1:2] == $past(hist[N_TAPS-3:0])));

endmodule

bind dfe_half_rate dfe_half_rate_chk #(.N_TAPS(N_TAPS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dec_valid (dec_valid),
    .dec_even  (dec_even),
    .dec_odd   (dec_odd),
    .stage_v   (st_q.v1),
    .hist      (st_q.hist),
    .e_if0     (e_if0),
    .e_if1     (e_if1),
    .o_if0     (o_if0),
    .o_if1     (o_if1)
);

// File: tb/dfe_half_rate_tb.sv
module dfe_half_rate_tb_top;

    typedef struct packed {
        logic       v;
        logic [7:0] w1, w2, w3, w4, w5;
        logic [7:0] xe, xo;
    } vec_t;

    typedef struct packed {
        logic v, e, o;
    } exp_t;

    localparam int NVEC = 14;
    // R3 R4 R5 R10: mixed weights per pair, including an idle gap
    localparam vec_t TBL [NVEC] = '{
        '{1'b1,  8'sd20,  8'sd10,  8'sd5,   8'sd3,  8'sd1,  8'sd40, -8'sd35},
        '{1'b1,  8'sd20,  8'sd10,  8'sd5,   8'sd3,  8'sd1, -8'sd12,  8'sd25},
        '{1'b1,  8'sd30, -8'sd15,  8'sd8,  -8'sd4,  8'sd2,  8'sd5,   -8'sd6},
        '{1'b1,  8'sd60,  8'sd0,   8'sd0,   8'sd0,  8'sd0,  8'sd50,  -8'sd20},
        '{1'b1,  8'sd60,  8'sd0,   8'sd0,   8'sd0,  8'sd0, -8'sd50,   8'sd20},
        '{1'b0,  8'sd99,  8'sd99,  8'sd99,  8'sd99, 8'sd99, 8'sd127, 8'sd127},
        '{1'b1,  8'sd0,   8'sd25,  8'sd0,   8'sd0,  8'sd0,  8'sd10,  -8'sd10},
        '{1'b1,  8'sd0,   8'sd0,   8'sd25,  8'sd0,  8'sd0, -8'sd20,   8'sd20},
        '{1'b1,  8'sd0,   8'sd0,   8'sd0,   8'sd25, 8'sd0,  8'sd15,  -8'sd15},
        '{1'b1,  8'sd0,   8'sd0,   8'sd0,   8'sd0,  8'sd25, -8'sd5,   8'sd5},
        '{1'b1, -8'sd40,  8'sd12, -8'sd9,   8'sd7, -8'sd3,  8'sd33,  -8'sd44},
        '{1'b1,  8'sd45,  8'sd22,  8'sd11,  8'sd6,  8'sd2, -8'sd70,   8'sd64},
        '{1'b1,  8'sd45,  8'sd22,  8'sd11,  8'sd6,  8'sd2,  8'sd1,   -8'sd1},
        '{1'b1, -8'sd128, 8'sd127,-8'sd128, 8'sd127,8'sd50, 8'sd100, -8'sd100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  samp_even = '0;
    logic [7:0]  samp_odd = '0;
    logic [39:0] tap_w = '0;
    logic        dec_even, dec_odd, dec_valid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [4:0] m_hist;
    exp_t       pend_old, pend_new;
    string      tag_old, tag_new;

    always #10 clk = ~clk;

    dfe_half_rate dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .samp_even (samp_even),
        .samp_odd  (samp_odd),
        .tap_w     (tap_w),
        .dec_even  (dec_even),
        .dec_odd   (dec_odd),
        .dec_valid (dec_valid)
    );

    function automatic int pol(input logic b);
        return b ? 1 : -1;
    endfunction

    function automatic int wt(input vec_t x, input int k);
        case (k)
            0: return int'($signed(x.w1));
            1: return int'($signed(x.w2));
            2: return int'($signed(x.w3));
            3: return int'($signed(x.w4));
            default: return int'($signed(x.w5));
        endcase
    endfunction

    // Equalization equation from R3..R6: earlier bits weighted by polarity.
    task automatic model(input vec_t x);
        int y;
        logic de, dq;
        logic [4:0] hp;
        y = int'($signed(x.xe));
        for (int k = 0; k < 5; k++) y -= wt(x, k) * pol(m_hist[k]);
        de = (y >= 0);
        hp = {m_hist[3:0], de};
        y = int'($signed(x.xo));
        for (int k = 0; k < 5; k++) y -= wt(x, k) * pol(hp[k]);
        dq = (y >= 0);
        m_hist = {m_hist[2:0], de, dq};
    endtask

    task automatic compare();
        exp_t got;
        got = '{dec_valid, dec_even, dec_odd};
        n_chk++;
        if (got !== pend_old) begin
            n_fail++;
            $display("FAIL %s: actual v/e/o=%b%b%b expected %b%b%b",
                     tag_old, got.v, got.e, got.o, pend_old.v, pend_old.e, pend_old.o);
        end
    endtask

    task automatic step(input vec_t x, input string tag);
        @(negedge clk);
        compare();
        pend_old  = pend_new;
        tag_old   = tag_new;
        in_valid  = x.v;
        samp_even = x.xe;
        samp_odd  = x.xo;
        tap_w     = {x.w5, x.w4, x.w3, x.w2, x.w1};
        if (x.v) model(x);
        pend_new  = '{x.v, m_hist[1], m_hist[0]};
        tag_new   = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_hist   = '0;          // R7: history starts as all -1
        pend_old = '0;
        pend_new = '0;
        tag_old  = "R1";
        tag_new  = "R1";
    endtask

    function automatic vec_t mk(input logic v, input int t1, input int t2, input int t3,
                                input int t4, input int t5, input int xe, input int xo);
        vec_t r;
        r = '{v, 8'(t1), 8'(t2), 8'(t3), 8'(t4), 8'(t5), 8'(xe), 8'(xo)};
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        do_reset();

        // table walk
        foreach (TBL[i]) step(TBL[i], TBL[i].v ? "R3 R4 R5 R10" : "R9");

        // R7: after reset, earlier bits count as -1 (tap 2 lifts -9 to +1)
        do_reset();
        step(mk(1, 0, 10, 0, 0, 0, -9, -30), "R7");
        step(mk(1, 0, 10, 0, 0, 0, -9, -30), "R7");

        // R6: exact zero slices to 1, minus one slices to 0
        step(mk(1, 0, 0, 0, 0, 0, 0, -1), "R6");
        step(mk(1, 0, 0, 0, 0, 0, -1, 0), "R6");

        // R4: odd tap 1 follows the same-word even decision
        step(mk(1, 100, 0, 0, 0, 0, 127, -50), "R4");
        step(mk(1, 100, 0, 0, 0, 0, -127, 50), "R4");

        // R8: extreme sums that an 8- or 10-bit sum would wrap
        step(mk(1, -128, -128, -128, -128, -128, 127, 127), "R8");
        step(mk(1, 127, 127, 127, 127, 127, -128, -128), "R8");
        step(mk(1, -128, -128, -128, -128, -128, -128, -128), "R8");
        step(mk(1, 127, 127, 127, 127, 127, 127, 127), "R8");

        // R9: idle cycles with junk leave decisions and history untouched
        step(mk(0, 90, 90, 90, 90, 90, -128, 127), "R9");
        step(mk(0, -90, 5, 5, 5, 5, 127, -128), "R9");
        step(mk(0, 1, 1, 1, 1, 1, 0, 0), "R9");
        step(mk(1, 40, 20, 10, 5, 2, 3, -3), "R9");

        // R2: isolated valid pulse, then drain
        step(mk(0, 0, 0, 0, 0, 0, 0, 0), "R2");
        step(mk(1, 0, 0, 0, 0, 0, 10, -10), "R2");
        step(mk(0, 0, 0, 0, 0, 0, 0, 0), "R2");
        step(mk(0, 0, 0, 0, 0, 0, 0, 0), "R2");
        step(mk(0, 0, 0, 0, 0, 0, 0, 0), "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R2: watchdog expired, actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule